// File: doc/BRIEF.md
# Burst-Mode ROM Read Controller

This block sits on the host side of an external asynchronous read-only memory whose array is read in aligned groups. A host request names a start address, a beat count and a width mode. The controller pulls chip enable and output enable low, drives the address, and waits a programmable number of clock cycles for the first word. Each following beat that stays inside the same aligned group changes only the lowest address bits and waits a shorter, separately programmed number of cycles. A beat that steps out of its group pays the full wait again.

In word mode a group is four 16-bit words. In byte mode a group is eight bytes, and one extra address line below the word address selects the byte. Only the low byte lane is taken in byte mode. Each beat is handed to the host on a valid/ready handshake together with its address, and a host that holds ready low freezes the address sequence. After the last beat the controller releases the memory and waits a programmable bus-release time before it takes the next request.

Top module: `brom_burst_rd`

## Requirements
- R1: While reset is high and in the first cycle after it, `rom_ce_n` and `rom_oe_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the controller is idle again, and a `req_valid` held high in that time has no effect.
- R3: In the cycle after acceptance, `rom_ce_n` and `rom_oe_n` go to 0 and the memory address is driven. The first beat's `rsp_valid` rises FULL_LAT clock edges after the accepting edge.
- R4: After a beat handshake, a next beat in the same aligned group presents `rsp_valid` BURST_LAT edges after the handshake edge.
- R5: Groups are aligned on unit address bits [1:0] in word mode and bits [2:0] in byte mode. A next beat whose unit address has these bits all zero waits FULL_LAT edges, as a first beat does.
- R6: `req_len` holds the beat count minus one. Byte mode uses all three bits (1 to 8 beats). Word mode uses bits [1:0] and ignores bit 2 (1 to 4 beats). Beat addresses step by +1 unit.
- R7: In byte mode, `rom_addr` is unit address bits [ADDR_W:1], `rom_lsb` is unit bit 0, and `rsp_data` is zero in bits [15:8] with `rom_data[7:0]` below. The upper `rom_data` lanes have no effect.
- R8: In word mode the top bit of `req_addr` is ignored, so the `rsp_addr` top bit is 0. `rom_lsb` is driven 0, and `rsp_data` is the full `rom_data` sampled at the end of the wait.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data`, `rsp_addr` and the memory address hold their values.
- R10: After the last beat's handshake, `rom_ce_n` and `rom_oe_n` return to 1 on the next edge. `req_ready` stays 0 for FLOAT_LAT cycles with the memory released.
- R11: While the memory stays enabled, its address changes only on the edge of a beat handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_addr | input | ADDR_W+1 | Start unit address (byte address in byte mode) |
| req_len | input | 3 | Beat count minus one |
| req_byte | input | 1 | 1 = byte mode, 0 = word mode |
| rsp_valid | output | 1 | Beat available |
| rsp_ready | input | 1 | Host takes the beat |
| rsp_data | output | DATA_W | Beat data |
| rsp_addr | output | ADDR_W+1 | Unit address of the beat |
| rom_ce_n | output | 1 | Memory chip enable, active low |
| rom_oe_n | output | 1 | Memory output enable, active low |
| rom_addr | output | ADDR_W | Memory word address |
| rom_lsb | output | 1 | Byte select line below the word address |
| rom_data | input | DATA_W | Memory data bus |

## Verification
The hard case is the handshake of a group's final beat: the address advances into a new group and the wait counter reloads in the same cycle, so the full-versus-short latency choice is made on that edge. The bench provokes this with runs that start just below a group boundary, in both widths, and with ready patterns that release a stalled beat exactly at the boundary. A per-cycle reference model predicts the cycle in which `rsp_valid` rises, and the bench memory model returns garbage whenever an address has not been held long enough. An early sample therefore shows up as wrong data, and a late one shows up as wrong timing.

// File: rtl/brom_pkg.sv
package brom_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_SHOW  = 2'd2,
        PH_FLOAT = 2'd3
    } phase_e;

    localparam int LANE_W = 8;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // true when the unit address is the last one of its aligned group
    function automatic logic grp_end(input logic [2:0] low, input logic byte_m);
        return byte_m ? (low == 3'b111) : (low[1:0] == 2'b11);
    endfunction

endpackage

// File: rtl/brom_addr_gen.sv
module brom_addr_gen import brom_pkg::*; #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W:0]   ld_addr,
    input  logic [2:0]        ld_len,
    input  logic              ld_byte,
    output logic [ADDR_W:0]   cur_addr,
    output logic              byte_q,
    output logic              last_beat,
    output logic              next_in_group,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_lsb
);
    logic [2:0] rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            rem      <= '0;
            byte_q   <= 1'b0;
        end else if (load) begin
            byte_q   <= ld_byte;
            cur_addr <= ld_byte ? ld_addr : {1'b0, ld_addr[ADDR_W-1:0]};
            rem      <= ld_byte ? ld_len : {1'b0, ld_len[1:0]};
        end else if (step) begin
            rem      <= rem - 3'd1;
            cur_addr <= byte_q ? (cur_addr + 1'b1)
                               : {1'b0, cur_addr[ADDR_W-1:0] + 1'b1};
        end
    end

    always_comb begin
        last_beat     = (rem == 3'd0);
        next_in_group = !grp_end(cur_addr[2:0], byte_q);
        mem_addr      = byte_q ? cur_addr[ADDR_W:1] : cur_addr[ADDR_W-1:0];
        mem_lsb       = byte_q & cur_addr[0];
    end

endmodule

// File: rtl/brom_seq.sv
module brom_seq import brom_pkg::*; #(
    parameter int FULL_LAT  = 13,
    parameter int BURST_LAT = 7,
    parameter int FLOAT_LAT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic rsp_ready,
    input  logic last_beat,
    input  logic next_in_group,
    output logic req_ready,
    output logic load,
    output logic step,
    output logic capture,
    output logic rsp_valid,
    output logic bus_on
);
    localparam int MAXL = max3(FULL_LAT, BURST_LAT, FLOAT_LAT);
    localparam int CW   = $clog2(MAXL + 1);

    phase_e        ph;
    logic [CW-1:0] cnt;

    always_comb begin
        req_ready = (ph == PH_IDLE);
        load      = req_ready && req_valid;
        rsp_valid = (ph == PH_SHOW);
        step      = rsp_valid && rsp_ready && !last_beat;
        capture   = (ph == PH_WAIT) && (cnt == '0);
        bus_on    = (ph == PH_WAIT) || (ph == PH_SHOW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (load) begin
                    ph  <= PH_WAIT;
                    cnt <= CW'(FULL_LAT - 1);
                end
                PH_WAIT: begin
                    if (cnt == '0) ph <= PH_SHOW;
                    else           cnt <= cnt - 1'b1;
                end
                PH_SHOW: if (rsp_ready) begin
                    if (last_beat) begin
                        ph  <= PH_FLOAT;
                        cnt <= CW'(FLOAT_LAT - 1);
                    end else begin
                        ph  <= PH_WAIT;
                        cnt <= next_in_group ? CW'(BURST_LAT - 1) : CW'(FULL_LAT - 1);
                    end
                end
                default: begin
                    if (cnt == '0) ph <= PH_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // the wait counter never exceeds the longest configured wait
    assert_wait_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WAIT) |-> (int'(cnt) < FULL_LAT || int'(cnt) < BURST_LAT));

    // a captured beat is always presented on the next cycle
    assert_capture_show_R4: assert property (@(posedge clk) disable iff (rst)
        capture |=> rsp_valid);

endmodule

// File: rtl/brom_capture.sv
module brom_capture import brom_pkg::*; #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              byte_q,
    input  logic [DATA_W-1:0] rom_data,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int HI_W = DATA_W - LANE_W;

    always_ff @(posedge clk) begin
        if (rst)
            rsp_data <= '0;
        else if (capture)
            rsp_data <= byte_q ? {{HI_W{1'b0}}, rom_data[LANE_W-1:0]} : rom_data;
    end

endmodule

// File: rtl/brom_burst_rd.sv
module brom_burst_rd import brom_pkg::*; #(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int FULL_LAT  = 13,
    parameter int BURST_LAT = 7,
    parameter int FLOAT_LAT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [2:0]        req_len,
    input  logic              req_byte,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W:0]   rsp_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_lsb,
    input  logic [DATA_W-1:0] rom_data
);
    localparam int GW = $clog2(FLOAT_LAT + 1);

    logic load, step, capture, bus_on;
    logic last_beat, next_in_group, byte_q;

    brom_seq #(
        .FULL_LAT (FULL_LAT),
        .BURST_LAT(BURST_LAT),
        .FLOAT_LAT(FLOAT_LAT)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .rsp_ready    (rsp_ready),
        .last_beat    (last_beat),
        .next_in_group(next_in_group),
        .req_ready    (req_ready),
        .load         (load),
        .step         (step),
        .capture      (capture),
        .rsp_valid    (rsp_valid),
        .bus_on       (bus_on)
    );

    brom_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .step         (step),
        .ld_addr      (req_addr),
        .ld_len       (req_len),
        .ld_byte      (req_byte),
        .cur_addr     (rsp_addr),
        .byte_q       (byte_q),
        .last_beat    (last_beat),
        .next_in_group(next_in_group),
        .mem_addr     (rom_addr),
        .mem_lsb      (rom_lsb)
    );

    brom_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .byte_q  (byte_q),
        .rom_data(rom_data),
        .rsp_data(rsp_data)
    );

    assign rom_ce_n = !bus_on;
    assign rom_oe_n = !bus_on;

    // cycles the memory has been released, saturating
    logic [GW-1:0] gap;
    always_ff @(posedge clk) begin
        if (rst)                    gap <= GW'(FLOAT_LAT);
        else if (!rom_ce_n)         gap <= '0;
        else if (int'(gap) < FLOAT_LAT) gap <= gap + 1'b1;
    end

    assert_release_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> (int'(gap) >= FLOAT_LAT));

    assert_ready_bus_off_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (rom_ce_n && rom_oe_n));

    assert_hold_beat_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
                                       && $stable(rsp_addr) && $stable(rom_addr)));

    assert_addr_moves_on_hs_R11: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n && $past(!rom_ce_n) && ($past(rom_addr) != rom_addr || $past(rom_lsb) != rom_lsb))
        |-> $past(rsp_valid && rsp_ready));

    assert_release_after_last_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(rom_ce_n) |-> $past(rsp_valid && rsp_ready));

    assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && byte_q) |-> (rsp_data[DATA_W-1:LANE_W] == '0));

endmodule

// File: tb/tb_brom_burst_rd.sv
module tb_brom_burst_rd;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam int FL = 6;
    localparam int BL = 3;
    localparam int TL = 2;
    localparam int NREQ = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic          req_valid, req_ready, req_byte, rsp_valid, rsp_ready;
    logic [AW:0]   req_addr, rsp_addr;
    logic [2:0]    req_len;
    logic [DW-1:0] rsp_data, rom_data;
    logic          rom_ce_n, rom_oe_n, rom_lsb;
    logic [AW-1:0] rom_addr;

    brom_burst_rd #(.ADDR_W(AW), .DATA_W(DW), .FULL_LAT(FL), .BURST_LAT(BL), .FLOAT_LAT(TL)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_byte(req_byte),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_addr(rsp_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_addr(rom_addr), .rom_lsb(rom_lsb), .rom_data(rom_data));

    int n_tests = 0;
    int n_fail  = 0;

    function automatic logic [15:0] word_of(input logic [AW-1:0] w);
        logic [31:0] p;
        p = {22'd0, w} * 32'h9E37 + 32'h1234;
        return p[15:0];
    endfunction

    function automatic logic [15:0] exp_data(input logic [AW:0] u, input bit b);
        logic [15:0] wd;
        if (b) begin
            wd = word_of(u[AW:1]);
            return {8'h00, u[0] ? wd[15:8] : wd[7:0]};
        end
        return word_of(u[AW-1:0]);
    endfunction

    // memory model: data valid only after the address was held long enough
    bit            mem_byte;
    int            age_h, age_l, eff_h, eff_l;
    logic [AW-3:0] hi_p;
    logic [2:0]    lo_p;
    logic          ce_p;
    logic [15:0]   wsel;
    always_comb begin
        eff_h = (ce_p || rom_addr[AW-1:2] != hi_p) ? 0 : age_h;
        eff_l = (ce_p || rom_addr[AW-1:2] != hi_p || {rom_addr[1:0], rom_lsb} != lo_p) ? 0 : age_l;
        wsel  = word_of(rom_addr);
        if (!rom_ce_n && !rom_oe_n && eff_h + 1 >= FL && eff_l + 1 >= BL)
            rom_data = mem_byte ? {8'hEE, rom_lsb ? wsel[15:8] : wsel[7:0]} : wsel;
        else
            rom_data = 16'hBAD1;
    end
    always @(posedge clk) begin
        if (rom_ce_n) begin
            age_h <= 0;
            age_l <= 0;
        end else begin
            age_h <= eff_h + 1;
            age_l <= eff_l + 1;
        end
        hi_p <= rom_addr[AW-1:2];
        lo_p <= {rom_addr[1:0], rom_lsb};
        ce_p <= rom_ce_n;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    logic [AW:0] r_addr [NREQ];
    logic [2:0]  r_len  [NREQ];
    bit          r_byte [NREQ];
    bit          r_stall[NREQ];

    int          m_ph, m_cnt, m_rem, idx;
    logic [AW:0] m_ua;
    bit          m_b, m_stall, done, in_grp;

    initial begin
        r_addr[0] = 11'h004; r_len[0] = 3'd3; r_byte[0] = 0; r_stall[0] = 0;
        r_addr[1] = 11'h0FE; r_len[1] = 3'd3; r_byte[1] = 0; r_stall[1] = 0;
        r_addr[2] = 11'h020; r_len[2] = 3'b101; r_byte[2] = 0; r_stall[2] = 1;
        r_addr[3] = 11'h013; r_len[3] = 3'd7; r_byte[3] = 1; r_stall[3] = 1;
        r_addr[4] = 11'h7FD; r_len[4] = 3'd2; r_byte[4] = 0; r_stall[4] = 0;
        r_addr[5] = 11'h006; r_len[5] = 3'd0; r_byte[5] = 1; r_stall[5] = 0;
        r_addr[6] = 11'h3FF; r_len[6] = 3'd1; r_byte[6] = 0; r_stall[6] = 1;

        rst = 1'b1; req_valid = 0; req_addr = '0; req_len = '0; req_byte = 0; rsp_ready = 0;
        mem_byte = 0; age_h = 0; age_l = 0; hi_p = '0; lo_p = '0; ce_p = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1, "R1 req_ready in reset", req_ready, 1);
        chk(rom_ce_n === 1'b1 && rom_oe_n === 1'b1, "R1 enables in reset", {rom_ce_n, rom_oe_n}, 2'b11);
        chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", rsp_valid, 0);
        rst = 1'b0;
        m_ph = 0; m_cnt = 0; m_rem = 0; m_ua = '0; m_b = 0; m_stall = 0; idx = 0; done = 0;

        for (int cyc = 0; cyc < 4000 && !done; cyc++) begin
            @(negedge clk);
            chk(req_ready === (m_ph == 0), "R2 R10 req_ready", req_ready, m_ph == 0);
            chk(rsp_valid === (m_ph == 2), "R3 R4 R5 rsp_valid timing", rsp_valid, m_ph == 2);
            chk(rom_ce_n === !(m_ph == 1 || m_ph == 2) && rom_oe_n === rom_ce_n,
                "R3 R10 enables", {rom_ce_n, rom_oe_n}, {2{!(m_ph == 1 || m_ph == 2)}});
            if (m_ph == 1 || m_ph == 2) begin
                if (m_b) begin
                    chk(rom_addr === m_ua[AW:1] && rom_lsb === m_ua[0], "R7 R11 byte memory address",
                        {rom_addr, rom_lsb}, {m_ua[AW:1], m_ua[0]});
                end else begin
                    chk(rom_addr === m_ua[AW-1:0] && rom_lsb === 1'b0, "R8 R11 word memory address",
                        {rom_addr, rom_lsb}, {m_ua[AW-1:0], 1'b0});
                end
            end
            if (m_ph == 2) begin
                chk(rsp_data === exp_data(m_ua, m_b), m_b ? "R7 byte beat data" : "R8 word beat data",
                    rsp_data, exp_data(m_ua, m_b));
                chk(rsp_addr === m_ua, "R6 R8 R9 beat address", rsp_addr, m_ua);
            end

            // drive inputs for the next edge
            req_valid = (idx < NREQ);
            if (idx < NREQ) begin
                req_addr = r_addr[idx]; req_len = r_len[idx]; req_byte = r_byte[idx];
            end
            rsp_ready = m_stall ? (cyc % 3 == 0) : 1'b1;

            // reference model step
            case (m_ph)
                0: if (req_valid) begin
                    m_b = req_byte;
                    mem_byte = req_byte;
                    m_ua = req_byte ? req_addr : {1'b0, req_addr[AW-1:0]};
                    m_rem = req_byte ? int'(req_len) : int'(req_len[1:0]);
                    m_stall = r_stall[idx];
                    m_ph = 1; m_cnt = FL - 1;
                    idx++;
                end
                1: if (m_cnt == 0) m_ph = 2; else m_cnt--;
                2: if (rsp_ready) begin
                    if (m_rem == 0) begin
                        m_ph = 3; m_cnt = TL - 1;
                    end else begin
                        in_grp = m_b ? (m_ua[2:0] != 3'b111) : (m_ua[1:0] != 2'b11);
                        m_ua = m_b ? m_ua + 1'b1 : {1'b0, m_ua[AW-1:0] + 1'b1};
                        m_rem--;
                        m_ph = 1; m_cnt = in_grp ? BL - 1 : FL - 1;
                    end
                end
                default: if (m_cnt == 0) m_ph = 0; else m_cnt--;
            endcase
            if (idx == NREQ && m_ph == 0) done = 1;
        end

        if (!done) chk(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule